// File: doc/BRIEF.md
# Serial Flash Sequence Table Engine

This block drives a single-data-line serial flash (serial clock, active-low chip select, data out, data in) from a small table of programmable instruction sequences, so no flash transaction is built into the logic. Software first fills the table through a configuration port, then freezes it with a key-protected lock. From then on a command port starts a transaction by naming a sequence index, together with a flash address and a data size.

The engine walks the chosen sequence one instruction at a time. Each instruction sends an opcode byte, sends the address, idles for dummy clocks, or moves data bytes. Received bytes are collected into a receive FIFO, and bytes to program are taken from a transmit FIFO. Chip select stays low for the whole sequence. The serial clock runs in SPI mode 0, with the half period set by a fixed divider of the system clock.

Top module: `flash_seq_engine`

## Requirements
- R1: After reset, csN is high, sck is low, busy is low, the receive FIFO is empty, every table word reads as zero and the table is locked.
- R2: A table write (cfgKind 0) takes effect only while the table is unlocked. Two control writes in a row are needed to change the lock state. The first is the key write (cfgKind 1, data equal to KEY). The second is the lock-control write (cfgKind 2), where data[1:0]=01 locks the table and 10 unlocks it. Any table write made while the table is locked leaves the table unchanged.
- R3: Sequence n uses table words 4n to 4n+3. Instruction k of the sequence sits in word 4n+k/2: bits [15:0] when k is even and bits [31:16] when k is odd. Each instruction holds a type in [15:10], a pad code in [9:8] and an operand in [7:0]. The type codes are: 1 opcode, 2 address, 3 dummy, 4 read, 5 write.
- R4: An opcode instruction shifts its operand out as one byte, MSB first.
- R5: An address instruction shifts out all 32 bits of cmdAddr when its operand is 32. For any other operand it shifts out only cmdAddr[23:0]. The address is sent MSB first.
- R6: A dummy instruction gives as many serial clocks as its operand, with mosi held low.
- R7: A read instruction captures as many bytes as its operand. Each byte is sampled MSB first on rising sck edges and pushed into the receive FIFO in order. A byte does not start while the receive FIFO is full.
- R8: A write instruction sends as many bytes as its operand, taking them from the transmit FIFO. An operand of zero uses cmdSize as the byte count instead. The serial clock stalls while the transmit FIFO is empty.
- R9: A sequence ends at the first instruction whose type is 0, whose type is above 5, or whose pad code is not 0. It also ends after its eighth instruction.
- R10: busy rises on the cycle after a start and stays high until the sequence completes. A start given while busy is ignored. csN stays low whenever sck is high. sck idles low and each high phase lasts CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgKind | input | 2 | 0 table word, 1 key, 2 lock control |
| cfgIdx | input | TAW | Table word index |
| cfgData | input | 32 | Configuration write data |
| cmdStart | input | 1 | Start pulse |
| cmdSeq | input | SW | Sequence index |
| cmdSize | input | SIZE_W | Data size used by write operand 0 |
| cmdAddr | input | 32 | Flash address |
| busy | output | 1 | Sequence in progress |
| txWrEn | input | 1 | Transmit FIFO push |
| txWrData | input | 8 | Transmit byte |
| txFull | output | 1 | Transmit FIFO full |
| rxRdEn | input | 1 | Receive FIFO pop |
| rxRdData | output | 8 | Receive FIFO head byte |
| rxEmpty | output | 1 | Receive FIFO empty |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A fast-read sequence with a 24-bit address, dummy clocks and a four-byte read checks the bit order of opcode, address and dummy cycles. It also checks that received bytes land at the right serial bit offset. Program sequences are run in two forms, one with a zero write operand and one with an explicit write operand. Comparing the two shows whether the byte count comes from cmdSize or from the operand. Starting a program with the transmit FIFO empty shows the clock stalling. A 32-bit address read, a full eight-instruction sequence, a sequence with a stop in its middle, and table writes made before unlock and after lock each show a different limit on what gets clocked out.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam logic [5:0] K_STOP  = 6'd0;
  localparam logic [5:0] K_CMD   = 6'd1;
  localparam logic [5:0] K_ADDR  = 6'd2;
  localparam logic [5:0] K_DUMMY = 6'd3;
  localparam logic [5:0] K_READ  = 6'd4;
  localparam logic [5:0] K_WRITE = 6'd5;

  typedef struct packed {
    logic [5:0] kind;
    logic [1:0] pad;
    logic [7:0] operand;
  } inst_t;

  // strobes from control to datapath
  typedef struct packed {
    logic        load;
    logic [7:0]  nBits;
    logic [31:0] value;
    logic        csOn;
  } dpCtl_t;
endpackage

// File: rtl/fse_fifo.sv
module fse_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] count;
  logic doPush, doPop;

  assign full = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign doPush = push && !full;
  assign doPop = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop) count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/fse_datapath.sv
module fse_datapath
  import fse_pkg::*;
#(
  parameter int NUM_SEQ = 16,
  parameter int CLK_DIV = 2,
  parameter logic [31:0] KEY = 32'h5AF0_5AF0,
  localparam int WORDS = NUM_SEQ * 4,
  localparam int TAW = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWe,
  input  logic [1:0]     cfgKind,
  input  logic [TAW-1:0] cfgIdx,
  input  logic [31:0]    cfgData,
  input  logic [TAW-1:0] rdIdx,
  output logic [31:0]    rdWord,
  input  dpCtl_t         ctl,
  output logic           unitDone,
  output logic [7:0]     shiftByte,
  output logic           sck,
  output logic           csN,
  output logic           mosi,
  input  logic           miso
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [31:0] tbl [WORDS];
  logic locked, armed;

  assign rdWord = tbl[rdIdx];

  // table store with key-guarded lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b1;
      armed <= 1'b0;
      for (int i = 0; i < WORDS; i++) tbl[i] <= '0;
    end else if (cfgWe) begin
      armed <= 1'b0;
      case (cfgKind)
        2'd0: if (!locked) tbl[cfgIdx] <= cfgData;
        2'd1: armed <= (cfgData == KEY);
        2'd2: if (armed) begin
          if (cfgData[1:0] == 2'b01) locked <= 1'b1;
          else if (cfgData[1:0] == 2'b10) locked <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  logic [31:0] shReg;
  logic [7:0] bitsLeft;
  logic [DW-1:0] divCnt;
  logic active, sckReg, inBit, doneP, csNReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      bitsLeft <= '0;
      divCnt <= '0;
      active <= 1'b0;
      sckReg <= 1'b0;
      inBit <= 1'b0;
      doneP <= 1'b0;
      csNReg <= 1'b1;
    end else begin
      doneP <= 1'b0;
      csNReg <= !ctl.csOn;
      if (ctl.load) begin
        shReg <= ctl.value;
        bitsLeft <= ctl.nBits;
        active <= 1'b1;
        divCnt <= '0;
        sckReg <= 1'b0;
      end else if (active) begin
        if (divCnt == DW'(CLK_DIV-1)) begin
          divCnt <= '0;
          if (!sckReg) begin
            sckReg <= 1'b1;
            inBit <= miso;
          end else begin
            sckReg <= 1'b0;
            shReg <= {shReg[30:0], inBit};
            bitsLeft <= bitsLeft - 1'b1;
            if (bitsLeft == 8'd1) begin
              active <= 1'b0;
              doneP <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign unitDone = doneP;
  assign shiftByte = shReg[7:0];
  assign sck = sckReg;
  assign csN = csNReg;
  assign mosi = active & shReg[31];
endmodule

// File: rtl/fse_control.sv
module fse_control
  import fse_pkg::*;
#(
  parameter int NUM_SEQ = 16,
  parameter int SIZE_W = 10,
  localparam int SW = $clog2(NUM_SEQ),
  localparam int TAW = SW + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [SW-1:0]     cmdSeq,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic [31:0]       cmdAddr,
  output logic              busy,
  output logic [TAW-1:0]    rdIdx,
  input  logic [31:0]       rdWord,
  output dpCtl_t            ctl,
  input  logic              unitDone,
  input  logic [7:0]        shiftByte,
  input  logic [7:0]        txData,
  input  logic              txEmpty,
  output logic              txPop,
  input  logic              rxFull,
  output logic              rxPush,
  output logic [7:0]        rxByte
);
  typedef enum logic [2:0] {S_IDLE, S_DECODE, S_UNIT, S_WAIT, S_END} state_e;

  state_e state;
  logic [SW-1:0] seqReg;
  logic [SIZE_W-1:0] sizeReg, remCnt, unitCnt;
  logic [31:0] addrReg;
  logic [2:0] instIdx;
  logic [5:0] kindReg;
  logic [7:0] opReg;
  inst_t cur;
  logic isExec, lastInst, unitReady;

  assign rdIdx = {seqReg, instIdx[2:1]};
  assign cur = instIdx[0] ? rdWord[31:16] : rdWord[15:0];
  assign isExec = (cur.pad == 2'd0) && (cur.kind >= K_CMD) && (cur.kind <= K_WRITE);
  assign lastInst = (instIdx == 3'd7);

  always_comb begin
    unitCnt = '0;
    case (cur.kind)
      K_CMD, K_ADDR: unitCnt = SIZE_W'(1);
      K_DUMMY: unitCnt = (cur.operand != 8'd0) ? SIZE_W'(1) : '0;
      K_READ: unitCnt = SIZE_W'(cur.operand);
      K_WRITE: unitCnt = (cur.operand != 8'd0) ? SIZE_W'(cur.operand) : sizeReg;
      default: unitCnt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      seqReg <= '0;
      sizeReg <= '0;
      addrReg <= '0;
      instIdx <= '0;
      remCnt <= '0;
      kindReg <= '0;
      opReg <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmdStart) begin
          seqReg <= cmdSeq;
          sizeReg <= cmdSize;
          addrReg <= cmdAddr;
          instIdx <= '0;
          state <= S_DECODE;
        end
        S_DECODE: begin
          kindReg <= cur.kind;
          opReg <= cur.operand;
          remCnt <= unitCnt;
          if (!isExec) state <= S_END;
          else if (unitCnt == '0) begin
            if (lastInst) state <= S_END;
            else instIdx <= instIdx + 1'b1;
          end else state <= S_UNIT;
        end
        S_UNIT: if (unitReady) state <= S_WAIT;
        S_WAIT: if (unitDone) begin
          if (remCnt == SIZE_W'(1)) begin
            if (lastInst) state <= S_END;
            else begin
              instIdx <= instIdx + 1'b1;
              state <= S_DECODE;
            end
          end else begin
            remCnt <= remCnt - 1'b1;
            state <= S_UNIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unitReady = 1'b1;
    if (kindReg == K_WRITE) unitReady = !txEmpty;
    else if (kindReg == K_READ) unitReady = !rxFull;
    ctl.load = (state == S_UNIT) && unitReady;
    ctl.csOn = (state == S_DECODE) || (state == S_UNIT) || (state == S_WAIT);
    ctl.nBits = 8'd8;
    ctl.value = '0;
    case (kindReg)
      K_CMD: ctl.value = {opReg, 24'd0};
      K_ADDR: begin
        ctl.nBits = (opReg == 8'd32) ? 8'd32 : 8'd24;
        ctl.value = (opReg == 8'd32) ? addrReg : {addrReg[23:0], 8'd0};
      end
      K_DUMMY: ctl.nBits = opReg;
      K_WRITE: ctl.value = {txData, 24'd0};
      default: ;
    endcase
  end

  assign txPop = ctl.load && (kindReg == K_WRITE);
  assign rxPush = (state == S_WAIT) && unitDone && (kindReg == K_READ);
  assign rxByte = shiftByte;
  assign busy = (state != S_IDLE);
endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
  import fse_pkg::*;
#(
  parameter int NUM_SEQ = 16,
  parameter int CLK_DIV = 2,
  parameter int SIZE_W = 10,
  parameter int FIFO_DEPTH = 8,
  parameter logic [31:0] KEY = 32'h5AF0_5AF0,
  localparam int SW = $clog2(NUM_SEQ),
  localparam int TAW = SW + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [TAW-1:0]    cfgIdx,
  input  logic [31:0]       cfgData,
  input  logic              cmdStart,
  input  logic [SW-1:0]     cmdSeq,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic [31:0]       cmdAddr,
  output logic              busy,
  input  logic              txWrEn,
  input  logic [7:0]        txWrData,
  output logic              txFull,
  input  logic              rxRdEn,
  output logic [7:0]        rxRdData,
  output logic              rxEmpty,
  output logic              sck,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);
  dpCtl_t ctl;
  logic [TAW-1:0] rdIdx;
  logic [31:0] rdWord;
  logic unitDone, txPop, txEmpty, rxPush, rxFull;
  logic [7:0] shiftByte, txData, rxByte;

  fse_control #(.NUM_SEQ(NUM_SEQ), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdSeq(cmdSeq),
    .cmdSize(cmdSize), .cmdAddr(cmdAddr), .busy(busy), .rdIdx(rdIdx),
    .rdWord(rdWord), .ctl(ctl), .unitDone(unitDone), .shiftByte(shiftByte),
    .txData(txData), .txEmpty(txEmpty), .txPop(txPop), .rxFull(rxFull),
    .rxPush(rxPush), .rxByte(rxByte)
  );

  fse_datapath #(.NUM_SEQ(NUM_SEQ), .CLK_DIV(CLK_DIV), .KEY(KEY)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .rdIdx(rdIdx), .rdWord(rdWord), .ctl(ctl),
    .unitDone(unitDone), .shiftByte(shiftByte), .sck(sck), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  fse_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(txWrEn), .pushData(txWrData), .pop(txPop),
    .headData(txData), .full(txFull), .empty(txEmpty)
  );

  fse_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(rxPush), .pushData(rxByte), .pop(rxRdEn),
    .headData(rxRdData), .full(rxFull), .empty(rxEmpty)
  );
endmodule

// File: rtl/fse_checker.sv
module fse_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic csN,
  input logic sck,
  input logic cmdStart,
  input logic txPop,
  input logic txEmpty,
  input logic rxPush,
  input logic rxFull
);
  p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rstN) !busy |-> csN);
  p_sck_idle_r10: assert property (@(posedge clk) disable iff (!rstN) !busy |-> !sck);
  p_sck_in_cs_r10: assert property (@(posedge clk) disable iff (!rstN) sck |-> !csN);
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rstN) (!busy && cmdStart) |=> busy);
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN) txPop |-> !txEmpty);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN) rxPush |-> !rxFull);
endmodule

bind flash_seq_engine fse_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .csN(csN), .sck(sck),
  .cmdStart(cmdStart), .txPop(txPop), .txEmpty(txEmpty),
  .rxPush(rxPush), .rxFull(rxFull)
);

// File: tb/tb_flash_seq_engine.sv
`timescale 1ns/1ps
module tb_flash_seq_engine;
  localparam logic [31:0] KEY = 32'h5AF0_5AF0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgKind = '0;
  logic [5:0] cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic cmdStart = 1'b0;
  logic [3:0] cmdSeq = '0;
  logic [9:0] cmdSize = '0;
  logic [31:0] cmdAddr = '0;
  logic busy, txFull, rxEmpty, sck, csN, mosi;
  logic txWrEn = 1'b0;
  logic [7:0] txWrData = '0;
  logic rxRdEn = 1'b0;
  logic [7:0] rxRdData;
  logic miso = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_seq_engine dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .cmdStart(cmdStart), .cmdSeq(cmdSeq), .cmdSize(cmdSize),
    .cmdAddr(cmdAddr), .busy(busy), .txWrEn(txWrEn), .txWrData(txWrData),
    .txFull(txFull), .rxRdEn(rxRdEn), .rxRdData(rxRdData), .rxEmpty(rxEmpty),
    .sck(sck), .csN(csN), .mosi(mosi), .miso(miso)
  );

  // ---------------- flash responder ----------------
  int bitCnt = 0;
  int csErr = 0;
  logic [7:0] cap [64];
  time tRise = 0;
  time hiLen = 0;

  function automatic logic [7:0] respByte(int k);
    return 8'((k * 29) ^ 8'h5A);
  endfunction

  function automatic logic respBit(int n);
    logic [7:0] b;
    b = respByte(n / 8);
    return b[7 - (n % 8)];
  endfunction

  always @(negedge csN) begin
    bitCnt = 0;
    miso = respBit(0);
  end

  always @(posedge sck) begin
    tRise = $time;
    if (csN) csErr++;
    if (bitCnt < 512) cap[bitCnt / 8][7 - (bitCnt % 8)] = mosi;
  end

  always @(negedge sck) begin
    hiLen = $time - tRise;
    bitCnt++;
    miso = respBit(bitCnt);
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic [5:0] k, input logic [7:0] op);
    return {k, 2'b00, op};
  endfunction

  task automatic cfgWrite(input logic [1:0] kind, input int idx, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgKind = kind;
    cfgIdx = 6'(idx);
    cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic startOnly(input int seq, input int size, input logic [31:0] addr);
    @(negedge clk);
    for (int i = 0; i < 64; i++) cap[i] = 8'h00;
    bitCnt = 0;
    cmdSeq = 4'(seq);
    cmdSize = 10'(size);
    cmdAddr = addr;
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic runSeq(input int seq, input int size, input logic [31:0] addr);
    startOnly(seq, size, addr);
    waitIdle();
  endtask

  task automatic pushTx(input logic [7:0] b);
    @(negedge clk);
    txWrEn = 1'b1;
    txWrData = b;
    @(negedge clk);
    txWrEn = 1'b0;
  endtask

  task automatic popRx(output logic [7:0] b);
    @(negedge clk);
    b = rxRdData;
    rxRdEn = 1'b1;
    @(negedge clk);
    rxRdEn = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(csN == 1'b1, "R1 csN", csN, 1);
    check(sck == 1'b0, "R1 sck", sck, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(rxEmpty == 1'b1, "R1 rxEmpty", rxEmpty, 1);
  endtask

  task automatic t_locked_at_reset();
    cfgWrite(2'd0, 4, {ins(6'd2, 8'd24), ins(6'd1, 8'h0B)});
    runSeq(1, 0, 32'h0);
    check(bitCnt == 0, "R2 write before unlock ignored", bitCnt, 0);
    check(busy == 1'b0, "R9 empty sequence ends", busy, 0);
  endtask

  task automatic load_table();
    cfgWrite(2'd1, 0, KEY);
    cfgWrite(2'd2, 0, 32'h2);
    cfgWrite(2'd0, 4, {ins(6'd2, 8'd24), ins(6'd1, 8'h0B)});
    cfgWrite(2'd0, 5, {ins(6'd4, 8'd4), ins(6'd3, 8'd8)});
    cfgWrite(2'd0, 8, {ins(6'd2, 8'd24), ins(6'd1, 8'h02)});
    cfgWrite(2'd0, 9, {16'h0, ins(6'd5, 8'd0)});
    cfgWrite(2'd0, 12, {ins(6'd2, 8'd32), ins(6'd1, 8'h0C)});
    cfgWrite(2'd0, 13, {16'h0, ins(6'd4, 8'd1)});
    for (int k = 0; k < 4; k++)
      cfgWrite(2'd0, 16 + k, {ins(6'd1, 8'(8'h81 + 2 * k)), ins(6'd1, 8'(8'h80 + 2 * k))});
    cfgWrite(2'd0, 20, {ins(6'd1, 8'hEE), ins(6'd1, 8'hEE)});
    cfgWrite(2'd0, 24, {ins(6'd0, 8'd0), ins(6'd1, 8'h06)});
    cfgWrite(2'd0, 25, {16'h0, ins(6'd1, 8'h77)});
    cfgWrite(2'd0, 28, {ins(6'd5, 8'd2), ins(6'd1, 8'h12)});
    cfgWrite(2'd1, 0, KEY);
    cfgWrite(2'd2, 0, 32'h1);
  endtask

  task automatic t_fast_read();
    logic [7:0] b;
    runSeq(1, 0, 32'h0012_3456);
    check(bitCnt == 72, "R3 fast read bit count", bitCnt, 72);
    check(cap[0] == 8'h0B, "R4 opcode", cap[0], 8'h0B);
    check({cap[1], cap[2], cap[3]} == 24'h123456, "R5 24-bit address",
          {cap[1], cap[2], cap[3]}, 24'h123456);
    check(cap[4] == 8'h00, "R6 dummy mosi low", cap[4], 0);
    check(hiLen == 40, "R10 sck high time", hiLen, 40);
    check(csErr == 0, "R10 cs low while clocking", csErr, 0);
    for (int k = 0; k < 4; k++) begin
      check(rxEmpty == 1'b0, "R7 rx not empty", rxEmpty, 0);
      popRx(b);
      check(b == respByte(5 + k), "R7 read byte", b, respByte(5 + k));
    end
    check(rxEmpty == 1'b1, "R7 rx count", rxEmpty, 1);
  endtask

  task automatic t_locked_write_ignored();
    logic [7:0] b;
    cfgWrite(2'd0, 4, {ins(6'd2, 8'd24), ins(6'd1, 8'h55)});
    runSeq(1, 0, 32'h0);
    check(cap[0] == 8'h0B, "R2 write after lock ignored", cap[0], 8'h0B);
    for (int k = 0; k < 4; k++) popRx(b);
  endtask

  task automatic t_program_size_stall();
    startOnly(2, 3, 32'h00AB_CDEF);
    repeat (200) @(negedge clk);
    check(busy == 1'b1, "R8 stalls on empty tx", busy, 1);
    check(bitCnt == 32, "R8 stall point", bitCnt, 32);
    pushTx(8'hA1);
    pushTx(8'hB2);
    pushTx(8'hC3);
    waitIdle();
    check(bitCnt == 56, "R8 cmdSize byte count", bitCnt, 56);
    check({cap[4], cap[5], cap[6]} == 24'hA1B2C3, "R8 write data",
          {cap[4], cap[5], cap[6]}, 24'hA1B2C3);
  endtask

  task automatic t_write_operand();
    pushTx(8'h3C);
    pushTx(8'hC3);
    runSeq(7, 5, 32'h0);
    check(bitCnt == 24, "R8 operand overrides size", bitCnt, 24);
    check({cap[1], cap[2]} == 16'h3CC3, "R8 explicit bytes", {cap[1], cap[2]}, 16'h3CC3);
  endtask

  task automatic t_addr32();
    logic [7:0] b;
    runSeq(3, 0, 32'h89AB_CDEF);
    check(bitCnt == 48, "R5 32-bit address count", bitCnt, 48);
    check({cap[1], cap[2], cap[3], cap[4]} == 32'h89ABCDEF, "R5 32-bit address",
          {cap[1], cap[2], cap[3], cap[4]}, 32'h89ABCDEF);
    popRx(b);
    check(b == respByte(5), "R7 read after 32-bit address", b, respByte(5));
  endtask

  task automatic t_eight_cap_busy();
    startOnly(4, 0, 32'h0);
    repeat (10) @(negedge clk);
    check(busy == 1'b1, "R10 busy during run", busy, 1);
    cmdSeq = 4'd6;
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    waitIdle();
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R10 start while busy ignored", busy, 0);
    check(bitCnt == 64, "R9 eight instruction limit", bitCnt, 64);
    check(cap[7] == 8'h87, "R3 instruction order", cap[7], 8'h87);
  endtask

  task automatic t_stop_mid();
    runSeq(6, 0, 32'h0);
    check(bitCnt == 8, "R9 stop type ends sequence", bitCnt, 8);
    check(cap[0] == 8'h06, "R4 opcode before stop", cap[0], 8'h06);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_at_reset();
    load_table();
    t_fast_read();
    t_locked_write_ignored();
    t_program_size_stall();
    t_write_operand();
    t_addr32();
    t_eight_cap_busy();
    t_stop_mid();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule